// File: doc/BRIEF.md
# Compare/Capture 16-bit Timer

This block is a 16-bit up-counter with one companion register. The companion register works either as a compare register or as a capture register. A 16-bit mode register sets the count source, the role of the companion register, clearing, one-shot halting and the count enable. A simple register bus reads and writes three locations: the mode register, the counter and the companion register.

Up to seven internal sources arrive as single-cycle tick strobes. The eighth source is an external pin. Its rising edges are synchronized and then counted. In compare mode the block raises a one-cycle event strobe each time the counter reaches the compare value. It can restart from zero on the tick after that, or it can halt itself in one-shot mode. In capture mode, a rising edge on the capture input latches the counter and can reset it.

The block has no streaming data path, so every pin is a plain control or status signal with no valid/ready back-pressure. Reads are combinational from `bus_sel`. Writes take effect at the clock edge where `bus_wr` is high.

Top module: `cct_timer16`

## Requirements
- R1: After reset, the mode register, the counter and the companion register all read 0, and `evt_o` is low.
- R2: The mode register has these fields:
  - source select at bits 2:0
  - clear enable at bit 4
  - one-shot at bit 6
  - role at bit 8 (0 = compare, 1 = capture)
  - count enable at bit 15

  All other bits, including 3 and 5, always read 0. Writing 0xFFFF reads back 0x8157.
- R3: While count enable is 1, the counter steps by one on each strobe of the selected source, `tick_in[sel]` for sel 0..6. Strobes of unselected sources have no effect. While count enable is 0, the counter holds.
- R4: With select value 7, each rising edge of `pin_in` advances the counter by exactly one, however long the pin stays high. The step becomes visible three clock edges after the pin rises.
- R5: With clear enable 0, the counter runs freely: 0xFFFF steps to 0x0000, and it passes the compare value without clearing.
- R6: In compare mode with clear enable 1, a tick taken while the counter equals the compare value loads 0 instead of incrementing. The count sequence therefore has a period of compare value + 1 ticks.
- R7: In compare mode, `evt_o` pulses for one cycle each time a tick moves the counter onto the compare value. This happens whether clear enable is 0 or 1.
- R8: In capture mode, a synchronized rising edge of `cap_in` copies the current counter into the companion register and pulses `evt_o`.
- R9: In capture mode with clear enable 1, the counter becomes 0 on the capture. In capture mode, the counter never clears on equality with the companion register.
- R10: In one-shot mode, the tick that causes a compare match also clears count enable, so the counter halts at the compare value. Writing count enable back to 1 restarts counting from the held value.
- R11: A bus write to the counter in the same cycle as a tick wins, so the written value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 7 | Internal count strobes, one per source 0..6 |
| pin_in | input | 1 | External count pin, asynchronous |
| cap_in | input | 1 | Capture trigger, asynchronous |
| bus_sel | input | 2 | Register select: 0 mode, 1 counter, 2 companion |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| evt_o | output | 1 | One-cycle compare-match or capture strobe |

## Verification
The mode register is swept one bit at a time, which separates implemented bits from reserved ones. The source select is swept over all seven internal strobes plus the pin, with every source pulsed each time, which shows that only the chosen source counts. Compare values 0 to 5 are each run for three full periods, and the bench predicts every counter value and the number of strobes arithmetically. Comparing runs with clear enable off, one-shot on, and capture mode with and without clearing tells apart the four ways the counter can leave the compare value.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int MODE_W = 16;

  localparam int BIT_CAE = 4;
  localparam int BIT_ONE = 6;
  localparam int BIT_CAP = 8;
  localparam int BIT_CNE = 15;

  localparam logic [MODE_W-1:0] MODE_IMPL_MASK = 16'h8157;

  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_CCR  = 2'd2
  } cct_addr_e;
endpackage

// File: rtl/cct_sync_rise.sv
module cct_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  // sh_q[STAGES-1] is the synchronized level; sh_q[STAGES] is its previous value
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cct_tick_sel.sv
module cct_tick_sel #(
  parameter int N_INT = 7,
  parameter int SEL_W = 3
) (
  input  logic [N_INT-1:0] tick_in,
  input  logic             pin_rise,
  input  logic [SEL_W-1:0] sel,
  input  logic             cne,
  output logic             tick
);
  localparam int NSRC = 1 << SEL_W;

  logic [NSRC-1:0] srcs;

  // the top select value is the pin; lower values are internal strobes
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == NSRC-1) begin : g_pin
      assign srcs[i] = pin_rise;
    end else if (i < N_INT) begin : g_int
      assign srcs[i] = tick_in[i];
    end else begin : g_none
      assign srcs[i] = 1'b0;
    end
  end

  assign tick = cne & srcs[sel];
endmodule

// File: rtl/cct_timer16.sv
module cct_timer16 import cct_pkg::*; #(
  parameter int W           = 16,
  parameter int SEL_W       = 3,
  parameter int N_INT       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_INT-1:0] tick_in,
  input  logic             pin_in,
  input  logic             cap_in,
  input  logic [1:0]       bus_sel,
  input  logic             bus_wr,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  output logic             evt_o
);
  // mode fields
  logic [SEL_W-1:0] src_q;
  logic             cae_q, one_q, capm_q, cne_q;
  // data registers
  logic [W-1:0]     cnt_q, ccr_q;
  logic [W-1:0]     cnt_d, ccr_d, cnt_adv;
  logic [MODE_W-1:0] mode_rd;
  logic             cne_d, evt_d;

  logic pin_rise, cap_rise, tick;
  logic mode_wr, cnt_wr, ccr_wr;
  logic at_cmp, cap_evt, hit;

  cct_sync_rise #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .rise (pin_rise)
  );

  cct_sync_rise #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cap_in),
    .rise (cap_rise)
  );

  cct_tick_sel #(.N_INT(N_INT), .SEL_W(SEL_W)) u_tick_sel (
    .tick_in (tick_in),
    .pin_rise(pin_rise),
    .sel     (src_q),
    .cne     (cne_q),
    .tick    (tick)
  );

  assign mode_wr = bus_wr && (bus_sel == ADDR_MODE);
  assign cnt_wr  = bus_wr && (bus_sel == ADDR_CNT);
  assign ccr_wr  = bus_wr && (bus_sel == ADDR_CCR);

  assign at_cmp  = !capm_q && (cnt_q == ccr_q);
  assign cap_evt = capm_q && cap_rise;
  assign cnt_adv = (cae_q && at_cmp) ? '0 : cnt_q + 1'b1;
  assign hit     = tick && !cnt_wr && !capm_q && (cnt_adv == ccr_q);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr)                cnt_d = bus_wdata;
    else if (cap_evt && cae_q) cnt_d = '0;
    else if (tick)             cnt_d = cnt_adv;
  end

  always_comb begin
    ccr_d = ccr_q;
    if (ccr_wr)       ccr_d = bus_wdata;
    else if (cap_evt) ccr_d = cnt_q;
  end

  always_comb begin
    cne_d = cne_q;
    if (mode_wr)           cne_d = bus_wdata[BIT_CNE];
    else if (hit && one_q) cne_d = 1'b0;
  end

  assign evt_d = hit || (cap_evt && !ccr_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      cae_q  <= 1'b0;
      one_q  <= 1'b0;
      capm_q <= 1'b0;
      cne_q  <= 1'b0;
      cnt_q  <= '0;
      ccr_q  <= '0;
      evt_o  <= 1'b0;
    end else begin
      if (mode_wr) begin
        src_q  <= bus_wdata[SEL_W-1:0];
        cae_q  <= bus_wdata[BIT_CAE];
        one_q  <= bus_wdata[BIT_ONE];
        capm_q <= bus_wdata[BIT_CAP];
      end
      cne_q <= cne_d;
      cnt_q <= cnt_d;
      ccr_q <= ccr_d;
      evt_o <= evt_d;
    end
  end

  always_comb begin
    mode_rd              = '0;
    mode_rd[SEL_W-1:0]   = src_q;
    mode_rd[BIT_CAE]     = cae_q;
    mode_rd[BIT_ONE]     = one_q;
    mode_rd[BIT_CAP]     = capm_q;
    mode_rd[BIT_CNE]     = cne_q;
  end

  always_comb begin
    case (bus_sel)
      ADDR_MODE: bus_rdata = W'(mode_rd);
      ADDR_CNT:  bus_rdata = cnt_q;
      ADDR_CCR:  bus_rdata = ccr_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cct_timer16_chk.sv
module cct_timer16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] ccr_q,
  input logic         cne_q,
  input logic         cae_q,
  input logic         one_q,
  input logic         capm_q,
  input logic         cnt_wr,
  input logic         cap_evt,
  input logic         bus_wr,
  input logic [1:0]   bus_sel,
  input logic [W-1:0] bus_rdata,
  input logic         evt_o
);
  localparam logic [W-1:0] IMPL = W'(16'h8157);

  // R2
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == 2'd0) |-> ((bus_rdata & ~IMPL) == '0));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr && !cap_evt) |=> $stable(cnt_q));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && !cap_evt && !(cae_q && !capm_q && cnt_q == ccr_q))
    |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

  // R6
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cae_q && !capm_q && cnt_q == ccr_q) |=> (cnt_q == '0));

  // R7
  evt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && !capm_q && !$past(bus_wr)) |-> (cnt_q == ccr_q));

  // R8
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !bus_wr) |=> (ccr_q == $past(cnt_q)));

  // R9
  cap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && cae_q && !cnt_wr) |=> (cnt_q == '0));

  // R10
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && one_q && !capm_q && !$past(bus_wr)) |-> !cne_q);
endmodule

bind cct_timer16 cct_timer16_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .cnt_q    (cnt_q),
  .ccr_q    (ccr_q),
  .cne_q    (cne_q),
  .cae_q    (cae_q),
  .one_q    (one_q),
  .capm_q   (capm_q),
  .cnt_wr   (cnt_wr),
  .cap_evt  (cap_evt),
  .bus_wr   (bus_wr),
  .bus_sel  (bus_sel),
  .bus_rdata(bus_rdata),
  .evt_o    (evt_o)
);

// File: tb/sim_cct_timer16.sv
module sim_cct_timer16;
  localparam logic [1:0] A_MODE = 2'd0, A_CNT = 2'd1, A_CCR = 2'd2;
  localparam logic [15:0] M_CNE = 16'h8000, M_CAP = 16'h0100,
                          M_ONE = 16'h0040, M_CAE = 16'h0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  tick_in = '0;
  logic        pin_in = 1'b0, cap_in = 1'b0;
  logic [1:0]  bus_sel = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        evt_o;

  int n_chk = 0, n_err = 0, evt_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cct_timer16 u0 (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .pin_in(pin_in),
    .cap_in(cap_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_o(evt_o)
  );

  always @(negedge clk) if (rst_n && evt_o) evt_seen++;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_sel = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tk(input int i);
    @(negedge clk);
    tick_in[i] = 1'b1;
    @(negedge clk);
    tick_in = '0;
  endtask

  task automatic pin_pulse();
    @(negedge clk); pin_in = 1'b1;
    repeat (3) @(negedge clk);
    pin_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cap_pulse();
    @(negedge clk); cap_in = 1'b1;
    repeat (3) @(negedge clk);
    cap_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    finish_run();
  end

  initial begin
    logic [15:0] v, expv;
    int e0, nexp;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_MODE, v); check("R1 mode", v, 16'h0);
    rd(A_CNT, v);  check("R1 cnt", v, 16'h0);
    rd(A_CCR, v);  check("R1 ccr", v, 16'h0);
    check("R1 evt", {15'b0, evt_o}, 16'h0);

    // R2 per-bit sweep of the mode register
    for (int b = 0; b < 16; b++) begin
      wr(A_MODE, 16'h1 << b);
      rd(A_MODE, v);
      check("R2 bit", v, (16'h1 << b) & 16'h8157);
    end
    wr(A_MODE, 16'hFFFF); rd(A_MODE, v); check("R2 all", v, 16'h8157);
    wr(A_MODE, 16'h0);

    // R3 source select: only the chosen strobe counts
    for (int s = 0; s < 7; s++) begin
      wr(A_MODE, M_CNE | 16'(s));
      wr(A_CNT, 16'h0);
      for (int i = 0; i < 7; i++) tk(i);
      rd(A_CNT, v); check("R3 select", v, 16'h1);
    end
    wr(A_MODE, 16'h0003);
    wr(A_CNT, 16'h0);
    tk(3);
    rd(A_CNT, v); check("R3 disabled", v, 16'h0);

    // R4 external pin source
    wr(A_MODE, M_CNE | 16'h7);
    wr(A_CNT, 16'h0);
    for (int i = 0; i < 7; i++) tk(i);
    for (int p = 1; p <= 5; p++) begin
      pin_pulse();
      rd(A_CNT, v); check("R4 pin", v, 16'(p));
    end

    // R5 free run wrap, passes compare value without clearing
    wr(A_MODE, M_CNE);
    wr(A_CCR, 16'h0002);
    wr(A_CNT, 16'hFFFD);
    @(negedge clk); e0 = evt_seen;
    expv = 16'hFFFD;
    for (int k = 0; k < 6; k++) begin
      tk(0); expv = expv + 16'h1;
      rd(A_CNT, v); check("R5 wrap", v, expv);
    end
    @(negedge clk);
    check("R7 free evt", 16'(evt_seen - e0), 16'h1);

    // R6 R7 clear on compare, sweep compare values
    for (int c = 0; c < 6; c++) begin
      wr(A_MODE, M_CNE | M_CAE);
      wr(A_CCR, 16'(c));
      wr(A_CNT, 16'h0);
      @(negedge clk); e0 = evt_seen;
      expv = 16'h0; nexp = 0;
      for (int k = 0; k < 3 * (c + 1); k++) begin
        tk(0);
        expv = (expv == 16'(c)) ? 16'h0 : expv + 16'h1;
        if (expv == 16'(c)) nexp++;
        rd(A_CNT, v); check("R6 period", v, expv);
      end
      @(negedge clk);
      check("R7 evt count", 16'(evt_seen - e0), 16'(nexp));
    end

    // R10 one-shot halt and restart, clear enabled
    wr(A_MODE, M_CNE | M_CAE | M_ONE);
    wr(A_CCR, 16'h0003);
    wr(A_CNT, 16'h0);
    for (int k = 0; k < 6; k++) tk(0);
    rd(A_CNT, v);  check("R10 halted cnt", v, 16'h3);
    rd(A_MODE, v); check("R10 cne cleared", v, M_CAE | M_ONE);
    wr(A_MODE, M_CNE | M_CAE | M_ONE);
    tk(0);
    rd(A_CNT, v); check("R10 restart clr", v, 16'h0);
    for (int k = 0; k < 5; k++) tk(0);
    rd(A_CNT, v); check("R10 halt again", v, 16'h3);
    // restart without clear continues upward
    wr(A_MODE, M_CNE | M_ONE);
    tk(0);
    rd(A_CNT, v); check("R10 restart inc", v, 16'h4);

    // R8 capture without clear
    for (int j = 0; j < 3; j++) begin
      wr(A_MODE, M_CNE | M_CAP);
      wr(A_CNT, 16'(10 + 7 * j));
      tk(0); tk(0);
      @(negedge clk); e0 = evt_seen;
      cap_pulse();
      rd(A_CCR, v); check("R8 captured", v, 16'(12 + 7 * j));
      rd(A_CNT, v); check("R8 cnt kept", v, 16'(12 + 7 * j));
      @(negedge clk);
      check("R8 evt", 16'(evt_seen - e0), 16'h1);
    end

    // R9 capture with clear
    wr(A_MODE, M_CNE | M_CAP | M_CAE);
    wr(A_CNT, 16'h0040);
    cap_pulse();
    rd(A_CCR, v); check("R9 captured", v, 16'h0040);
    rd(A_CNT, v); check("R9 cleared", v, 16'h0);
    for (int k = 0; k < 66; k++) tk(0);
    rd(A_CNT, v); check("R9 no eq clear", v, 16'd66);

    // R11 bus write beats a simultaneous tick
    wr(A_MODE, M_CNE);
    wr(A_CNT, 16'h0020);
    @(negedge clk);
    bus_sel = A_CNT; bus_wr = 1'b1; bus_wdata = 16'h0100; tick_in[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_in = '0;
    rd(A_CNT, v); check("R11 write wins", v, 16'h0100);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule